// File: doc/BRIEF.md
# Uncacheable Access Ordering Fence Unit

This unit sits between a core's load/store issue stage and the platform port for uncacheable memory. Each incoming request carries an operation code, a speculation class, a tag, an address and write data. Loads and stores that are not speculative enter an in-order queue. From there they go to the platform one at a time and in exactly the order they were accepted. Speculative loads are not allowed to touch non-speculative uncacheable space. They never reach the platform port. Instead the unit answers them locally one cycle later, either with a NaT indication or with a zero value.

The platform reports two separate events for every request it has been sent. The first is a visibility acknowledgment. The second, usually later, is a completion acknowledgment, meaning the request's side effects are now in place. The unit counts the two events independently and offers two fence operations. The ordinary fence waits until every earlier request has been sent and has been acknowledged as visible. The acceptance fence waits until every earlier request has been acknowledged as complete. While a fence is pending, the request handshake is held off. A fence retires with a one-cycle done pulse.

Top module: `uc_order_fence`

## Requirements
- R1: After reset the outputs are as follows: `req_ready`=1, `bus_valid`=0, `fence_done`=0, `dfr_valid`=0, `q_full`=0 and `ack_err`=0.
- R2: The following requests appear on the bus in acceptance order, each carrying its tag, address and data:
  - loads (`req_op`=0) with `req_spec`=0;
  - stores (`req_op`=1), for which `bus_write`=1.
  The bus fields stay stable while `bus_valid` is high and `bus_ready` is low.
- R3: A load with `req_spec`≠0 never reaches the bus. In the cycle after it is accepted, `dfr_valid`=1 and `dfr_tag` carries its tag.
  - With `req_spec`=1 (control-speculative), `dfr_nat`=1.
  - With `req_spec`=2 or 3 (data-speculative), `dfr_nat`=0 and `dfr_data`=0.
- R4: An ordinary fence (`req_op`=2) holds `req_ready` low until no earlier request is unsent or awaiting its visibility acknowledgment.
  - `req_ready` returns high in the first cycle in which that condition holds.
  - `fence_done` pulses with `fence_kind`=0 in the following cycle.
- R5: An acceptance fence (`req_op`=3) behaves in the same way, except that it waits until no earlier request is awaiting its completion acknowledgment. Its done pulse carries `fence_kind`=1.
- R6: A fence accepted while nothing is outstanding leaves `req_ready` high in the next cycle. `fence_done` pulses in the cycle after that.
- R7: Visibility and completion acknowledgments are counted separately.
  - A request that is visible but not yet complete releases an ordinary fence.
  - The same request keeps an acceptance fence stalled.
- R8: The queue holds at most DEPTH (default 8) entries, counted from acceptance until the completion acknowledgment.
  - At that occupancy `q_full`=1 and `req_ready`=0, and no request is accepted.
  - Each completion acknowledgment frees one slot.
- R9: `ack_err` pulses for one cycle after either of these events:
  - a `vis_ack` while no sent request is awaiting visibility;
  - a `cmp_ack` while no sent request is awaiting completion.
  Such an acknowledgment leaves all counts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_op | input | 2 | 0 load, 1 store, 2 ordinary fence, 3 acceptance fence |
| req_spec | input | 2 | 0 none, 1 control-speculative, 2/3 data-speculative |
| req_tag | input | TAG_W | Destination tag |
| req_addr | input | ADDR_W | Address |
| req_wdata | input | DATA_W | Store data |
| bus_valid | output | 1 | Request presented to platform |
| bus_ready | input | 1 | Platform takes the presented request |
| bus_write | output | 1 | 1 for store |
| bus_tag | output | TAG_W | Tag of presented request |
| bus_addr | output | ADDR_W | Address of presented request |
| bus_wdata | output | DATA_W | Data of presented request |
| vis_ack | input | 1 | One request became visible |
| cmp_ack | input | 1 | One request completed |
| dfr_valid | output | 1 | Deferred speculative load answer |
| dfr_tag | output | TAG_W | Tag of deferred load |
| dfr_nat | output | 1 | NaT indication for control speculation |
| dfr_data | output | DATA_W | Returned value (zero) |
| fence_done | output | 1 | Fence retired this cycle |
| fence_kind | output | 1 | 0 ordinary, 1 acceptance |
| q_full | output | 1 | Queue at capacity |
| ack_err | output | 1 | Acknowledgment with nothing outstanding |

## Verification
Two events can fall in the same cycle: a pending fence reaching its release condition, and the acceptance of the next request. The bench holds a fence stalled behind a sent request and then delivers the single acknowledgment that satisfies the fence. It judges the result on two things. First, `req_ready` must rise in exactly the cycle after that acknowledgment. Second, `fence_done` must follow one cycle later with the correct kind. A second case gives a request visibility without completion. Under that condition the ordinary fence must release, while the acceptance fence must stay blocked until `cmp_ack`.

// File: rtl/uc_fence_pkg.sv
package uc_fence_pkg;
    typedef enum logic [1:0] {
        OP_LOAD      = 2'd0,
        OP_STORE     = 2'd1,
        OP_FENCE_VIS = 2'd2,
        OP_FENCE_CMP = 2'd3
    } uc_op_e;

    typedef enum logic [1:0] {
        SP_NONE     = 2'd0,
        SP_CTRL     = 2'd1,
        SP_DATA     = 2'd2,
        SP_DATA_ALT = 2'd3
    } uc_spec_e;
endpackage

// File: rtl/uc_fence_queue.sv
module uc_fence_queue #(
    parameter int DEPTH = 8,
    parameter int EW    = 53
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [EW-1:0] push_data,
    input  logic          bus_ready,
    output logic          bus_valid,
    output logic [EW-1:0] bus_data,
    input  logic          cmp_ack,
    output logic          full,
    output logic          cnt_zero,
    output logic          unsent_zero,
    output logic          sent_zero
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] iss;
        logic [CW-1:0] cnt;
        logic [CW-1:0] sent;
    } q_st_t;

    q_st_t s_d, s_q;
    logic [EW-1:0] mem_q [DEPTH];
    logic fire, retire;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign bus_valid   = (s_q.cnt != s_q.sent);
    assign bus_data    = mem_q[s_q.iss];
    assign fire        = bus_valid && bus_ready;
    assign retire      = cmp_ack && (s_q.sent != '0);
    assign full        = (s_q.cnt == CW'(DEPTH));
    assign cnt_zero    = (s_q.cnt == '0);
    assign unsent_zero = !bus_valid;
    assign sent_zero   = (s_q.sent == '0);

    always_comb begin
        s_d = s_q;
        if (push) s_d.wr = nxt(s_q.wr);
        if (fire) s_d.iss = nxt(s_q.iss);
        s_d.cnt  = s_q.cnt + CW'(push) - CW'(retire);
        s_d.sent = s_q.sent + CW'(fire) - CW'(retire);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[s_q.wr] <= push_data;
    end
endmodule

// File: rtl/uc_fence_ack_track.sv
module uc_fence_ack_track #(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_fire,
    input  logic vis_ack,
    input  logic cmp_ack,
    input  logic sent_zero,
    output logic vis_zero,
    output logic ack_err
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [CW-1:0] vis;
        logic          err;
    } t_st_t;

    t_st_t s_d, s_q;
    logic vis_bad, cmp_bad;

    assign vis_bad  = vis_ack && (s_q.vis == '0);
    assign cmp_bad  = cmp_ack && sent_zero;
    assign vis_zero = (s_q.vis == '0);
    assign ack_err  = s_q.err;

    always_comb begin
        s_d     = s_q;
        s_d.vis = s_q.vis + CW'(bus_fire) - CW'(vis_ack && !vis_bad);
        s_d.err = vis_bad || cmp_bad;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/uc_fence_ctrl.sv
module uc_fence_ctrl #(
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fence_acc,
    input  logic             fence_cmp,
    input  logic             spec_acc,
    input  logic             spec_nat,
    input  logic [TAG_W-1:0] spec_tag,
    input  logic             vis_idle,
    input  logic             cmp_idle,
    output logic             pend,
    output logic             release_now,
    output logic             fence_done,
    output logic             fence_kind,
    output logic             dfr_valid,
    output logic [TAG_W-1:0] dfr_tag,
    output logic             dfr_nat
);
    typedef struct packed {
        logic             pend;
        logic             kind;
        logic             done;
        logic             done_kind;
        logic             dv;
        logic [TAG_W-1:0] dtag;
        logic             dnat;
    } c_st_t;

    c_st_t s_d, s_q;

    assign pend        = s_q.pend;
    assign release_now = s_q.pend && (s_q.kind ? cmp_idle : vis_idle);
    assign fence_done  = s_q.done;
    assign fence_kind  = s_q.done_kind;
    assign dfr_valid   = s_q.dv;
    assign dfr_tag     = s_q.dtag;
    assign dfr_nat     = s_q.dnat;

    always_comb begin
        s_d           = s_q;
        s_d.done      = release_now;
        s_d.done_kind = s_q.kind;
        if (release_now) s_d.pend = 1'b0;
        if (fence_acc) begin
            s_d.pend = 1'b1;
            s_d.kind = fence_cmp;
        end
        s_d.dv = spec_acc;
        if (spec_acc) begin
            s_d.dtag = spec_tag;
            s_d.dnat = spec_nat;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/uc_order_fence.sv
module uc_order_fence #(
    parameter int DEPTH  = 8,
    parameter int TAG_W  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [1:0]        req_spec,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              bus_valid,
    input  logic              bus_ready,
    output logic              bus_write,
    output logic [TAG_W-1:0]  bus_tag,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              vis_ack,
    input  logic              cmp_ack,
    output logic              dfr_valid,
    output logic [TAG_W-1:0]  dfr_tag,
    output logic              dfr_nat,
    output logic [DATA_W-1:0] dfr_data,
    output logic              fence_done,
    output logic              fence_kind,
    output logic              q_full,
    output logic              ack_err
);
    import uc_fence_pkg::*;

    localparam int EW = 1 + TAG_W + ADDR_W + DATA_W;

    logic          accept, push, fence_acc, spec_acc, is_load, is_fence;
    logic          cnt_zero, unsent_zero, sent_zero, vis_zero;
    logic          vis_idle, cmp_idle, pend, release_now;
    logic [EW-1:0] bus_data;

    assign is_load   = (uc_op_e'(req_op) == OP_LOAD);
    assign is_fence  = req_op[1];
    assign req_ready = !q_full && (!pend || release_now);
    assign accept    = req_valid && req_ready;
    assign spec_acc  = accept && is_load && (uc_spec_e'(req_spec) != SP_NONE);
    assign push      = accept && !is_fence && !spec_acc;
    assign fence_acc = accept && is_fence;
    assign vis_idle  = vis_zero && unsent_zero;
    assign cmp_idle  = cnt_zero;
    assign dfr_data  = '0;
    assign {bus_write, bus_tag, bus_addr, bus_wdata} = bus_data;

    uc_fence_queue #(.DEPTH(DEPTH), .EW(EW)) u_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (push),
        .push_data   ({(uc_op_e'(req_op) == OP_STORE), req_tag, req_addr, req_wdata}),
        .bus_ready   (bus_ready),
        .bus_valid   (bus_valid),
        .bus_data    (bus_data),
        .cmp_ack     (cmp_ack),
        .full        (q_full),
        .cnt_zero    (cnt_zero),
        .unsent_zero (unsent_zero),
        .sent_zero   (sent_zero)
    );

    uc_fence_ack_track #(.DEPTH(DEPTH)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_fire  (bus_valid && bus_ready),
        .vis_ack   (vis_ack),
        .cmp_ack   (cmp_ack),
        .sent_zero (sent_zero),
        .vis_zero  (vis_zero),
        .ack_err   (ack_err)
    );

    uc_fence_ctrl #(.TAG_W(TAG_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .fence_acc   (fence_acc),
        .fence_cmp   (uc_op_e'(req_op) == OP_FENCE_CMP),
        .spec_acc    (spec_acc),
        .spec_nat    (uc_spec_e'(req_spec) == SP_CTRL),
        .spec_tag    (req_tag),
        .vis_idle    (vis_idle),
        .cmp_idle    (cmp_idle),
        .pend        (pend),
        .release_now (release_now),
        .fence_done  (fence_done),
        .fence_kind  (fence_kind),
        .dfr_valid   (dfr_valid),
        .dfr_tag     (dfr_tag),
        .dfr_nat     (dfr_nat)
    );
endmodule

// File: rtl/uc_order_fence_chk.sv
module uc_order_fence_chk #(
    parameter int TAG_W  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_op,
    input logic [1:0]        req_spec,
    input logic [TAG_W-1:0]  req_tag,
    input logic              bus_valid,
    input logic              bus_ready,
    input logic              bus_write,
    input logic [TAG_W-1:0]  bus_tag,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              dfr_valid,
    input logic [TAG_W-1:0]  dfr_tag,
    input logic              q_full,
    input logic              fence_done,
    input logic              fence_kind,
    input logic              vis_idle,
    input logic              cmp_idle
);
    a_r2_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_tag) && $stable(bus_addr)
                                    && $stable(bus_wdata) && $stable(bus_write));

    a_r3_spec_defer: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_op == 2'd0 && req_spec != 2'd0
        |=> dfr_valid && dfr_tag == $past(req_tag));

    a_r4_vis_release: assert property (@(posedge clk) disable iff (!rst_n)
        fence_done && !fence_kind |-> $past(vis_idle));

    a_r5_cmp_release: assert property (@(posedge clk) disable iff (!rst_n)
        fence_done && fence_kind |-> $past(cmp_idle));

    a_r8_no_accept_full: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> !req_ready);
endmodule

bind uc_order_fence uc_order_fence_chk #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/uc_order_fence_tb.sv
module uc_order_fence_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TAG_W = 4, ADDR_W = 16, DATA_W = 32, DEPTH = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, bus_ready = 1'b0, vis_ack = 1'b0, cmp_ack = 1'b0;
    logic [1:0] req_op = '0, req_spec = '0;
    logic [TAG_W-1:0] req_tag = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic req_ready, bus_valid, bus_write, dfr_valid, dfr_nat;
    logic fence_done, fence_kind, q_full, ack_err;
    logic [TAG_W-1:0] bus_tag, dfr_tag;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata, dfr_data;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uc_order_fence #(.DEPTH(DEPTH), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (.*);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send(input logic [1:0] op, input logic [1:0] sp, input logic [TAG_W-1:0] tg,
                        input logic [ADDR_W-1:0] ad, input logic [DATA_W-1:0] dt);
        req_valid = 1'b1; req_op = op; req_spec = sp; req_tag = tg; req_addr = ad; req_wdata = dt;
        while (!req_ready) tick();
        tick();
        req_valid = 1'b0;
    endtask

    task automatic pulse(input bit v, input bit c, input int n);
        vis_ack = v; cmp_ack = c;
        repeat (n) tick();
        vis_ack = 1'b0; cmp_ack = 1'b0;
    endtask

    task automatic t_reset();
        chk(req_ready == 1, "R1 ready", req_ready, 1);
        chk(bus_valid == 0, "R1 bus_valid", bus_valid, 0);
        chk(fence_done == 0 && dfr_valid == 0, "R1 done/dfr", {fence_done, dfr_valid}, 0);
        chk(q_full == 0 && ack_err == 0, "R1 full/err", {q_full, ack_err}, 0);
    endtask

    task automatic t_order();
        logic [ADDR_W-1:0] ea [3] = '{16'h0100, 16'h0204, 16'h0308};
        logic [1:0] eo [3] = '{2'd1, 2'd0, 2'd1};
        for (int i = 0; i < 3; i++) send(eo[i], 2'd0, TAG_W'(i + 1), ea[i], 32'hA000 + i);
        tick();
        chk(bus_valid == 1 && bus_addr == ea[0], "R2 held addr", bus_addr, ea[0]);
        bus_ready = 1'b1;
        for (int i = 0; i < 3; i++) begin
            chk(bus_valid && bus_addr == ea[i] && bus_tag == TAG_W'(i + 1), "R2 order addr", bus_addr, ea[i]);
            chk(bus_write == eo[i][0], "R2 write flag", bus_write, eo[i][0]);
            if (eo[i] == 2'd1) chk(bus_wdata == 32'hA000 + i, "R2 data", bus_wdata, 32'hA000 + i);
            tick();
        end
        bus_ready = 1'b0;
        chk(bus_valid == 0, "R2 drained", bus_valid, 0);
        pulse(1, 1, 3);
    endtask

    task automatic t_spec();
        send(2'd0, 2'd1, 4'd5, 16'h0040, 0);
        chk(dfr_valid && dfr_tag == 4'd5 && dfr_nat == 1, "R3 ctrl nat", {dfr_valid, dfr_tag, dfr_nat}, {1'b1, 4'd5, 1'b1});
        chk(bus_valid == 0, "R3 no bus ctrl", bus_valid, 0);
        send(2'd0, 2'd2, 4'd9, 16'h0044, 0);
        chk(dfr_valid && dfr_tag == 4'd9 && dfr_nat == 0 && dfr_data == 0, "R3 data zero", {dfr_tag, dfr_nat}, {4'd9, 1'b0});
        send(2'd0, 2'd3, 4'd3, 16'h0048, 0);
        chk(dfr_valid && dfr_nat == 0 && dfr_data == 0, "R3 alt data zero", dfr_nat, 0);
        tick();
        chk(dfr_valid == 0 && bus_valid == 0, "R3 never on bus", {dfr_valid, bus_valid}, 0);
    endtask

    task automatic t_fences();
        send(2'd1, 2'd0, 4'd7, 16'h0500, 32'h55);
        bus_ready = 1'b1; tick(); bus_ready = 1'b0;
        send(2'd2, 2'd0, 4'd0, 0, 0);
        chk(req_ready == 0, "R4 stall vis", req_ready, 0);
        tick(); tick();
        chk(req_ready == 0 && fence_done == 0, "R4 still stalled", {req_ready, fence_done}, 0);
        pulse(1, 0, 1);
        chk(req_ready == 1 && fence_done == 0, "R4 release cycle", {req_ready, fence_done}, 2'b10);
        tick();
        chk(fence_done == 1 && fence_kind == 0, "R4 done ordinary R7", {fence_done, fence_kind}, 2'b10);
        send(2'd3, 2'd0, 4'd0, 0, 0);
        chk(req_ready == 0, "R5 stall cmp", req_ready, 0);
        pulse(0, 1, 1);
        chk(req_ready == 1, "R5 release cycle", req_ready, 1);
        tick();
        chk(fence_done == 1 && fence_kind == 1, "R5 done acceptance", {fence_done, fence_kind}, 2'b11);
    endtask

    task automatic t_vis_only();
        send(2'd0, 2'd0, 4'd2, 16'h0600, 0);
        bus_ready = 1'b1; tick(); bus_ready = 1'b0;
        send(2'd3, 2'd0, 4'd0, 0, 0);
        pulse(1, 0, 1);
        tick();
        chk(req_ready == 0 && fence_done == 0, "R7 visible not complete", {req_ready, fence_done}, 0);
        pulse(0, 1, 1);
        chk(req_ready == 1, "R7 complete releases", req_ready, 1);
        tick();
        chk(fence_done == 1 && fence_kind == 1, "R7 done", {fence_done, fence_kind}, 2'b11);
    endtask

    task automatic t_empty_fence();
        tick();
        send(2'd2, 2'd0, 4'd0, 0, 0);
        chk(req_ready == 1 && fence_done == 0, "R6 no stall", {req_ready, fence_done}, 2'b10);
        tick();
        chk(fence_done == 1 && fence_kind == 0, "R6 done next", {fence_done, fence_kind}, 2'b10);
    endtask

    task automatic t_full();
        for (int i = 0; i < DEPTH; i++) send(2'd1, 2'd0, TAG_W'(i), ADDR_W'(16'h0700 + i), 32'(i));
        chk(q_full == 1 && req_ready == 0, "R8 full", {q_full, req_ready}, 2'b10);
        req_valid = 1'b1; req_op = 2'd1; req_addr = 16'h0EEE;
        tick();
        req_valid = 1'b0;
        bus_ready = 1'b1;
        repeat (DEPTH) tick();
        bus_ready = 1'b0;
        pulse(1, 0, DEPTH);
        pulse(0, 1, 1);
        chk(q_full == 0 && req_ready == 1, "R8 slot freed", {q_full, req_ready}, 2'b01);
        pulse(0, 1, DEPTH - 1);
        chk(bus_valid == 0, "R8 extra not accepted", bus_valid, 0);
    endtask

    task automatic t_err();
        pulse(1, 0, 1);
        chk(ack_err == 1, "R9 stray vis", ack_err, 1);
        tick();
        chk(ack_err == 0, "R9 pulse ends", ack_err, 0);
        pulse(0, 1, 1);
        chk(ack_err == 1, "R9 stray cmp", ack_err, 1);
        send(2'd3, 2'd0, 4'd0, 0, 0);
        chk(req_ready == 1, "R9 counts unchanged", req_ready, 1);
        tick();
        chk(fence_done == 1 && fence_kind == 1, "R9 fence immediate", {fence_done, fence_kind}, 2'b11);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_spec();
        t_fences();
        t_vis_only();
        t_empty_fence();
        t_full();
        t_err();
        repeat (3) tick();
        summary();
    end
endmodule